// File: doc/BRIEF.md
# Received Data Match Detector

This block sits beside the receive path of an SPI controller and inspects every word that arrives within a frame. A three-bit mode select picks one of several pattern rules. The rules compare incoming words against two stored 32-bit values. They look at the first word only or at every word, at a single word or at an ordered pair of words, and they use exact or masked comparison. When the selected rule is satisfied, a sticky match flag is raised. Software clears the flag by writing a one to it. An interrupt request follows the flag whenever the match interrupt enable is set.

Received words arrive on a valid/ready stream. The detector never applies back-pressure: `rx_ready` is high in every cycle out of reset, so a word is consumed in any cycle where `rx_valid` is high. A word is counted only in a cycle where both `rx_valid` and `rx_ready` are high. The start-of-frame pulse restarts position tracking. If `sof` is high together with a word, that word is the first word of the new frame. If `sof` is high alone, the next accepted word is the first word.

Top module: `rx_match_detector`

## Requirements
- R1: With `mode_sel` = 0 (off) or 1 (reserved), no received word ever sets `match_flag`.
- R2: With `mode_sel` = 2, the flag sets when the first word of a frame equals `match_val0` or `match_val1`. Later words have no effect.
- R3: With `mode_sel` = 3, the flag sets when any word of the frame equals `match_val0` or `match_val1`.
- R4: With `mode_sel` = 4, the flag sets when the first word of the frame equals `match_val0` and the second word equals `match_val1`.
- R5: With `mode_sel` = 5, the flag sets when any word equal to `match_val1` directly follows a word equal to `match_val0` in the same frame.
- R6: With `mode_sel` = 6, the flag sets when (first word & `match_val1`) equals (`match_val0` & `match_val1`).
- R7: With `mode_sel` = 7, the masked comparison of R6 is applied to every word of the frame.
- R8: `match_irq` is high exactly when `match_flag` is high and `irq_en` is 1.
- R9: `match_flag` stays high until a cycle with `flag_clr` = 1. When a match and a clear fall in the same cycle, the flag stays high.
- R10: `sof` restarts word position and forgets the previous word, so a pair is never matched across two frames.
- R11: The flag rises on the clock edge that accepts the matching word. Cycles with `rx_valid` low change nothing. `rx_ready` is 1 in every cycle after reset, and `match_flag` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Match rule select (0..7) |
| match_val0 | input | 32 | First stored compare value |
| match_val1 | input | 32 | Second stored compare value, also the mask in masked modes |
| rx_valid | input | 1 | Received word present |
| rx_ready | output | 1 | Detector accepts a word (always 1) |
| rx_data | input | 32 | Received word |
| sof | input | 1 | Start-of-frame pulse |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Match interrupt enable |
| match_flag | output | 1 | Sticky match flag |
| match_irq | output | 1 | Gated interrupt request |

## Verification
The flag is registered. A word accepted at one rising edge shows its effect on `match_flag` right after that same edge. The bench therefore drives each word on a falling edge and samples the flag on the following falling edge, one half period after the accepting edge. `match_irq` is a direct gate of the flag, so it is sampled in the same place. A clear strobe acts at the next rising edge and is checked on the falling edge after it. Negative cases, such as a pair split by `sof`, are checked after the last word of the stimulus.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

  typedef enum logic [2:0] {
    MODE_OFF        = 3'd0,
    MODE_RSVD       = 3'd1,
    MODE_FIRST_ANY  = 3'd2,
    MODE_EVERY_ANY  = 3'd3,
    MODE_FIRST_PAIR = 3'd4,
    MODE_EVERY_PAIR = 3'd5,
    MODE_FIRST_MASK = 3'd6,
    MODE_EVERY_MASK = 3'd7
  } mdet_mode_e;

  // position of the current word within its frame
  typedef struct packed {
    logic is_first;
    logic is_second;
    logic prev_m0;
  } pos_ctx_t;

endpackage

// File: rtl/mdet_frame_tracker.sv
module mdet_frame_tracker
  import mdet_pkg::*;
#(
  parameter int POS_LIMIT = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sof,
  input  logic     accept,
  input  logic     word_is_m0,
  output pos_ctx_t ctx
);
  localparam int POS_W = $clog2(POS_LIMIT + 1);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(POS_LIMIT);

  logic [POS_W-1:0] pos_q;
  logic             prev_q;
  logic [POS_W-1:0] pos_eff;
  logic             prev_eff;

  // a start-of-frame pulse makes the word beside it the first word
  always_comb begin
    pos_eff  = sof ? '0 : pos_q;
    prev_eff = sof ? 1'b0 : prev_q;
    ctx.is_first  = (pos_eff == '0);
    ctx.is_second = (pos_eff == POS_W'(1));
    ctx.prev_m0   = prev_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      prev_q <= 1'b0;
    end else if (accept) begin
      pos_q  <= (pos_eff == POS_MAX) ? POS_MAX : pos_eff + POS_W'(1);
      prev_q <= word_is_m0;
    end else if (sof) begin
      pos_q  <= '0;
      prev_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdet_compare.sv
module mdet_compare
  import mdet_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        mode_sel,
  input  logic [DATA_W-1:0] match_val0,
  input  logic [DATA_W-1:0] match_val1,
  input  logic [DATA_W-1:0] word,
  input  pos_ctx_t          ctx,
  output logic              word_is_m0,
  output logic              hit
);
  logic [DATA_W-1:0] mask_diff;
  logic              eq0, eq1, masked_eq;
  mdet_mode_e        mode;

  // per-bit masked mismatch: a bit counts only where the mask bit is set
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask_bit
    assign mask_diff[b] = match_val1[b] & (word[b] ^ match_val0[b]);
  end

  assign eq0        = (word == match_val0);
  assign eq1        = (word == match_val1);
  assign masked_eq  = ~|mask_diff;
  assign word_is_m0 = eq0;
  assign mode       = mdet_mode_e'(mode_sel);

  always_comb begin
    unique case (mode)
      MODE_FIRST_ANY:  hit = ctx.is_first & (eq0 | eq1);
      MODE_EVERY_ANY:  hit = eq0 | eq1;
      MODE_FIRST_PAIR: hit = ctx.is_second & ctx.prev_m0 & eq1;
      MODE_EVERY_PAIR: hit = ctx.prev_m0 & eq1;
      MODE_FIRST_MASK: hit = ctx.is_first & masked_eq;
      MODE_EVERY_MASK: hit = masked_eq;
      default:         hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/mdet_flag.sv
module mdet_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // a set beats a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rx_match_detector.sv
module rx_match_detector
  import mdet_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic [DATA_W-1:0] match_val0,
  input  logic [DATA_W-1:0] match_val1,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              sof,
  input  logic              flag_clr,
  input  logic              irq_en,
  output logic              match_flag,
  output logic              match_irq
);
  logic     accept;
  logic     word_is_m0;
  logic     hit;
  pos_ctx_t ctx;

  assign rx_ready  = rst_n;
  assign accept    = rx_valid & rx_ready;
  assign match_irq = match_flag & irq_en;

  mdet_frame_tracker #(.POS_LIMIT(2)) u_track (
    .clk(clk), .rst_n(rst_n), .sof(sof), .accept(accept),
    .word_is_m0(word_is_m0), .ctx(ctx)
  );

  mdet_compare #(.DATA_W(DATA_W)) u_cmp (
    .mode_sel(mode_sel), .match_val0(match_val0), .match_val1(match_val1),
    .word(rx_data), .ctx(ctx), .word_is_m0(word_is_m0), .hit(hit)
  );

  mdet_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(accept & hit), .clr(flag_clr),
    .flag(match_flag)
  );
endmodule

// File: rtl/rx_match_detector_chk.sv
module rx_match_detector_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_sel,
  input logic [DATA_W-1:0] match_val0,
  input logic [DATA_W-1:0] match_val1,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              flag_clr,
  input logic              irq_en,
  input logic              match_flag,
  input logic              match_irq
);
  AST_OFF_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag && mode_sel[2:1] == 2'b00) |=> !match_flag); // R1
  AST_ANY_EQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode_sel == 3'd3 && (rx_data == match_val0 || rx_data == match_val1)) |=> match_flag); // R3
  AST_MASK_EVERY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode_sel == 3'd7 && ((rx_data & match_val1) == (match_val0 & match_val1))) |=> match_flag); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !match_irq); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !match_flag |-> !match_irq); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag); // R9
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && flag_clr && !rx_valid) |=> !match_flag); // R9
  AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag && !rx_valid) |=> !match_flag); // R11
endmodule

bind rx_match_detector rx_match_detector_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .match_val0(match_val0),
  .match_val1(match_val1), .rx_valid(rx_valid), .rx_data(rx_data),
  .flag_clr(flag_clr), .irq_en(irq_en), .match_flag(match_flag),
  .match_irq(match_irq)
);

// File: tb/rx_match_detector_tb.sv
module rx_match_detector_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] V0 = 32'hA5A5_0001;
  localparam logic [31:0] V1 = 32'h5A5A_0002;
  localparam logic [31:0] XW = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [31:0] match_val0 = V0;
  logic [31:0] match_val1 = V1;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [31:0] rx_data = '0;
  logic        sof = 1'b0;
  logic        flag_clr = 1'b0;
  logic        irq_en = 1'b0;
  logic        match_flag;
  logic        match_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_match_detector u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .match_val0(match_val0),
    .match_val1(match_val1), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sof(sof), .flag_clr(flag_clr), .irq_en(irq_en),
    .match_flag(match_flag), .match_irq(match_irq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one word on a falling edge; returns one falling edge later
  task automatic send(input logic [31:0] d, input logic first);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; sof = first;
    @(negedge clk);
    rx_valid = 1'b0; sof = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check(match_flag, 1'b0, "R11 flag after reset");
    check(match_irq, 1'b0, "R8 irq after reset");
    check(rx_ready, 1'b1, "R11 ready");
  endtask

  task automatic t_off();
    mode_sel = 3'd0;
    send(V0, 1'b1); send(V1, 1'b0);
    check(match_flag, 1'b0, "R1 mode0");
    mode_sel = 3'd1;
    send(V0, 1'b1); send(V1, 1'b0);
    check(match_flag, 1'b0, "R1 mode1");
  endtask

  task automatic t_first_any();
    mode_sel = 3'd2;
    send(V1, 1'b1);
    check(match_flag, 1'b1, "R2 first word = val1");
    clear_flag();
    check(match_flag, 1'b0, "R9 cleared");
    send(XW, 1'b1); send(V0, 1'b0);
    check(match_flag, 1'b0, "R2 later word ignored");
  endtask

  task automatic t_every_any();
    mode_sel = 3'd3;
    send(XW, 1'b1); send(XW, 1'b0);
    check(match_flag, 1'b0, "R3 no match yet");
    send(V1, 1'b0);
    check(match_flag, 1'b1, "R3 third word matches");
    clear_flag();
  endtask

  task automatic t_first_pair();
    mode_sel = 3'd4;
    send(V0, 1'b1); send(V1, 1'b0);
    check(match_flag, 1'b1, "R4 first pair");
    clear_flag();
    send(XW, 1'b1); send(V0, 1'b0); send(V1, 1'b0);
    check(match_flag, 1'b0, "R4 late pair ignored");
  endtask

  task automatic t_every_pair();
    mode_sel = 3'd5;
    send(XW, 1'b1); send(V0, 1'b0); send(V1, 1'b0);
    check(match_flag, 1'b1, "R5 later pair");
    clear_flag();
    send(V0, 1'b1); send(XW, 1'b0); send(V1, 1'b0);
    check(match_flag, 1'b0, "R5 broken pair");
    send(V0, 1'b1); send(V1, 1'b1);
    check(match_flag, 1'b0, "R10 pair split by sof");
    send(V0, 1'b0);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    send(V1, 1'b0);
    check(match_flag, 1'b0, "R10 lone sof breaks pair");
  endtask

  task automatic t_mask();
    match_val0 = 32'h0000_0012; match_val1 = 32'h0000_00FF;
    mode_sel = 3'd6;
    send(32'hABCD_0012, 1'b1);
    check(match_flag, 1'b1, "R6 masked first");
    clear_flag();
    send(XW, 1'b1); send(32'h7777_7712, 1'b0);
    check(match_flag, 1'b0, "R6 masked second ignored");
    mode_sel = 3'd7;
    send(XW, 1'b1); send(32'h7777_7713, 1'b0);
    check(match_flag, 1'b0, "R7 masked mismatch");
    send(32'h7777_7712, 1'b0);
    check(match_flag, 1'b1, "R7 masked any");
    clear_flag();
    match_val0 = V0; match_val1 = V1;
  endtask

  task automatic t_irq();
    mode_sel = 3'd3;
    irq_en = 1'b0;
    send(V0, 1'b1);
    check(match_irq, 1'b0, "R8 irq gated off");
    irq_en = 1'b1;
    #1;
    check(match_irq, 1'b1, "R8 irq on");
    clear_flag();
    check(match_irq, 1'b0, "R8 irq follows clear");
    irq_en = 1'b0;
  endtask

  task automatic t_collision();
    mode_sel = 3'd3;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = V0; sof = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; sof = 1'b0; flag_clr = 1'b0;
    check(match_flag, 1'b1, "R9 set wins over clear");
    clear_flag();
  endtask

  task automatic t_valid_low();
    mode_sel = 3'd3;
    @(negedge clk);
    rx_data = V0;
    @(negedge clk);
    check(match_flag, 1'b0, "R11 valid low ignored");
    mode_sel = 3'd2;
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    send(V1, 1'b0);
    check(match_flag, 1'b1, "R10 lone sof then first word");
    clear_flag();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_first_any();
    t_every_any();
    t_first_pair();
    t_every_pair();
    t_mask();
    t_irq();
    t_collision();
    t_valid_low();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule